// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Software Force

This block turns the event strobes of a PWM time base into two registered output waveforms, A and B. Three events can reach it, one strobe each: the counter reaching zero, the counter meeting the first compare value while counting up, and the counter meeting the second compare value while counting up. For each output, a 16-bit control word gives every event a 2-bit action. The action can leave the output alone, drive it low, drive it high or invert it. A normal-polarity pulse is set on zero and cleared on its compare-up event, so its high time equals the compare value in ticks. Swapping the two actions inverts the polarity.

A continuous force register sits above the action tables. It can hold either output high or low for as long as it is programmed, whatever events arrive. Software uses it to park a disabled channel at its idle level: low for normal polarity, high for inverted polarity. All configuration comes in through a simple write port. The asynchronous active-low reset is released to the logic through a short synchronizer.

Top module: `pwm_aq`

## Requirements
- R1: While reset is asserted, and after it is released, both outputs are low and every action field and force field holds 0, so that zero, compare-A and compare-B strobes leave the outputs low until the control words are written.
- R2: An action field encodes 0 as keep, 1 as drive low, 2 as drive high and 3 as invert. The action is applied at the rising clock edge that samples its event strobe high, so the output shows the new level right after that edge.
- R3: In each control word, bits 1:0 give the zero-event action, bits 5:4 give the compare-A-up action and bits 9:8 give the compare-B-up action. All other bits have no effect.
- R4: Address 0 writes the control word of output A, address 1 writes that of output B, address 2 writes the force register, and address 3 is ignored. A write takes effect at its clock edge, so it governs events from the following cycle on.
- R5: When several strobed events carry a non-keep action for the same output in the same cycle, compare-B beats compare-A and compare-A beats zero. A strobed event whose action is keep does not block a lower-priority event.
- R6: Force field c sits at bits 2c+1:2c (A at 1:0, B at 3:2). Value 1 holds the output low and value 2 holds it high. The output reaches the forced level one edge after the write, and events are ignored while the force lasts.
- R7: Force values 0 and 3 both mean no force. When a force is released, the output keeps its forced level until the next event with a non-keep action.
- R8: With set-on-zero and clear-on-compare-up, and a time base of period P, the output is high for exactly the compare value in ticks per period. A compare value of 0 gives a constant low.
- R9: With clear-on-zero and set-on-compare-up, the output is low for the compare value in ticks per period. A compare value of 0 gives a constant high.
- R10: In a cycle with no strobed event and no active force, the output does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_zero | input | 1 | Time-base counter equals zero (one-cycle strobe) |
| evt_cmpa_up | input | 1 | Counter equals compare A while counting up |
| evt_cmpb_up | input | 1 | Counter equals compare B while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control A, 1 control B, 2 force, 3 unused |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Registered PWM output A |
| pwm_b | output | 1 | Registered PWM output B |

## Verification
The state is small: two control words, a force word and two output flops. A corrupted output flop shows at the port at once, and it persists until the next event whose action is not keep. A wrong control word or a wrong priority shows at the first edge that samples the affected event. A force field that is stored wrongly shows one edge after its write. The bench therefore checks the outputs every cycle after each stimulus, and it measures whole periods of high time against the compare values.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  // Per-event action encoding
  typedef enum logic [1:0] {
    AQ_KEEP = 2'd0,
    AQ_LOW  = 2'd1,
    AQ_HIGH = 2'd2,
    AQ_FLIP = 2'd3
  } aq_act_e;

  // Continuous force encoding (3 behaves like 0)
  typedef enum logic [1:0] {
    FRC_NONE     = 2'd0,
    FRC_LOW      = 2'd1,
    FRC_HIGH     = 2'd2,
    FRC_NONE_ALT = 2'd3
  } aq_frc_e;

  localparam int unsigned AQ_FIELD_W      = 2;
  // Distance between the zero field and each compare field
  localparam int unsigned AQ_FIELD_STRIDE = 4;

  function automatic logic aq_apply(input aq_act_e act, input logic cur);
    logic nxt;
    case (act)
      AQ_LOW:  nxt = 1'b0;
      AQ_HIGH: nxt = 1'b1;
      AQ_FLIP: nxt = ~cur;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pwm_aq_rst_sync.sv
module pwm_aq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [DATA_W-1:0]      ctrl_q [NUM_CH],
  output logic [2*NUM_CH-1:0]    frc_q
);

  localparam int unsigned FRC_W    = 2 * NUM_CH;
  localparam int unsigned FRC_ADDR = NUM_CH;

  logic [NUM_CH-1:0] ctrl_we;
  logic              frc_we;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      ctrl_we[i] = wr_en && (wr_addr == ADDR_W'(i));
    end
    frc_we = wr_en && (wr_addr == ADDR_W'(FRC_ADDR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        ctrl_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ctrl_we[i]) begin
          ctrl_q[i] <= wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_q <= '0;
    end else if (frc_we) begin
      frc_q <= wr_data[FRC_W-1:0];
    end
  end

endmodule

// File: rtl/pwm_aq_evsel.sv
module pwm_aq_evsel
  import pwm_aq_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_CMP = 2
) (
  input  logic [DATA_W-1:0]  ctrl,
  input  logic               evt_zero,
  input  logic [NUM_CMP-1:0] evt_cmp,
  output aq_act_e            act
);

  // Lowest priority first; a later non-keep action overrides
  always_comb begin
    act = AQ_KEEP;
    if (evt_zero) begin
      act = aq_act_e'(ctrl[AQ_FIELD_W-1:0]);
    end
    for (int k = 0; k < NUM_CMP; k++) begin
      if (evt_cmp[k] &&
          (ctrl[AQ_FIELD_STRIDE*(k+1) +: AQ_FIELD_W] != AQ_KEEP)) begin
        act = aq_act_e'(ctrl[AQ_FIELD_STRIDE*(k+1) +: AQ_FIELD_W]);
      end
    end
  end

endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  aq_act_e act,
  input  aq_frc_e frc,
  output logic    pwm_q
);

  logic pwm_d;
  logic pwm_en;

  always_comb begin
    case (frc)
      FRC_LOW: begin
        pwm_d  = 1'b0;
        pwm_en = 1'b1;
      end
      FRC_HIGH: begin
        pwm_d  = 1'b1;
        pwm_en = 1'b1;
      end
      default: begin
        pwm_d  = aq_apply(act, pwm_q);
        pwm_en = (act != AQ_KEEP);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (pwm_en) begin
      pwm_q <= pwm_d;
    end
  end

endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
  import pwm_aq_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_zero,
  input  logic              evt_cmpa_up,
  input  logic              evt_cmpb_up,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);

  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned FRC_W   = 2 * NUM_CH;

  logic                rst_sync_n;
  logic [DATA_W-1:0]   ctrl_words [NUM_CH];
  logic [FRC_W-1:0]    frc_word;
  logic [NUM_CMP-1:0]  evt_cmp;
  logic [NUM_CH-1:0]   pwm_q;

  assign evt_cmp = {evt_cmpb_up, evt_cmpa_up};

  pwm_aq_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_aq_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_words),
    .frc_q   (frc_word)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    aq_act_e act;

    pwm_aq_evsel #(
      .DATA_W  (DATA_W),
      .NUM_CMP (NUM_CMP)
    ) u_sel (
      .ctrl     (ctrl_words[ch]),
      .evt_zero (evt_zero),
      .evt_cmp  (evt_cmp),
      .act      (act)
    );

    pwm_aq_chan u_chan (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .act   (act),
      .frc   (aq_frc_e'(frc_word[2*ch +: 2])),
      .pwm_q (pwm_q[ch])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];

endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_zero,
  input logic        evt_cmpa,
  input logic        evt_cmpb,
  input logic [15:0] ctrl_a,
  input logic [3:0]  frc,
  input logic        pwm_a,
  input logic        pwm_b
);

  logic frc_a_idle;
  logic frc_b_idle;
  assign frc_a_idle = (frc[1:0] == 2'd0) || (frc[1:0] == 2'd3);
  assign frc_b_idle = (frc[3:2] == 2'd0) || (frc[3:2] == 2'd3);

  // R6
  r6_force_low_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc[1:0] == 2'd1) |=> !pwm_a);

  // R6
  r6_force_high_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc[3:2] == 2'd2) |=> pwm_b);

  // R10
  r10_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_zero && !evt_cmpa && !evt_cmpb && frc_a_idle) |=> $stable(pwm_a));

  // R10
  r10_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_zero && !evt_cmpa && !evt_cmpb && frc_b_idle) |=> $stable(pwm_b));

  // R5
  r5_cmp_over_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_zero && evt_cmpa && !evt_cmpb && frc_a_idle &&
     (ctrl_a[5:4] == 2'd1)) |=> !pwm_a);

  // R2
  r2_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_zero && !evt_cmpa && !evt_cmpb && frc_a_idle &&
     (ctrl_a[1:0] == 2'd3)) |=> (pwm_a != $past(pwm_a)));

endmodule

bind pwm_aq pwm_aq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .evt_zero (evt_zero),
  .evt_cmpa (evt_cmpa_up),
  .evt_cmpb (evt_cmpb_up),
  .ctrl_a   (ctrl_words[0]),
  .frc      (frc_word),
  .pwm_a    (pwm_a),
  .pwm_b    (pwm_b)
);

// File: tb/pwm_aq_test.sv
`timescale 1ns/1ps
module pwm_aq_test;

  logic        clk;
  logic        rst_n;
  logic        evt_zero, evt_cmpa_up, evt_cmpb_up;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pwm_a, pwm_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pwm_aq uut (
    .clk(clk), .rst_n(rst_n),
    .evt_zero(evt_zero), .evt_cmpa_up(evt_cmpa_up), .evt_cmpb_up(evt_cmpb_up),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Row: [27:24] req, [23] we, [22:21] addr, [20:5] data,
  //      [4:2] zero/cmpa/cmpb strobes, [1:0] expected a/b after the edge
  localparam int NV = 30;
  localparam logic [27:0] VEC [NV] = '{
    {4'd4, 1'b1, 2'd0, 16'h0012, 3'b000, 2'b00}, // R4 ctrl A normal
    {4'd4, 1'b1, 2'd1, 16'h0102, 3'b000, 2'b00}, // R4 ctrl B normal
    {4'd2, 1'b0, 2'd0, 16'h0000, 3'b100, 2'b11}, // R2 set on zero
    {4'd10,1'b0, 2'd0, 16'h0000, 3'b000, 2'b11}, // R10 hold
    {4'd3, 1'b0, 2'd0, 16'h0000, 3'b010, 2'b01}, // R3 cmpa clears A only
    {4'd3, 1'b0, 2'd0, 16'h0000, 3'b001, 2'b00}, // R3 cmpb clears B
    {4'd5, 1'b0, 2'd0, 16'h0000, 3'b110, 2'b01}, // R5 cmpa beats zero
    {4'd5, 1'b0, 2'd0, 16'h0000, 3'b101, 2'b10}, // R5 keep does not block
    {4'd4, 1'b1, 2'd0, 16'h0003, 3'b000, 2'b10}, // R4 A toggle on zero
    {4'd2, 1'b0, 2'd0, 16'h0000, 3'b100, 2'b01}, // R2 toggle
    {4'd2, 1'b0, 2'd0, 16'h0000, 3'b100, 2'b11}, // R2 toggle back
    {4'd3, 1'b1, 2'd0, 16'hCCC3, 3'b000, 2'b11}, // R3 filler bits set
    {4'd3, 1'b0, 2'd0, 16'h0000, 3'b011, 2'b10}, // R3 filler bits ignored
    {4'd3, 1'b0, 2'd0, 16'h0000, 3'b100, 2'b01}, // R3 zero field still toggles
    {4'd4, 1'b1, 2'd3, 16'h0005, 3'b000, 2'b01}, // R4 address 3
    {4'd4, 1'b0, 2'd0, 16'h0000, 3'b000, 2'b01}, // R4 address 3 ignored
    {4'd2, 1'b0, 2'd0, 16'h0000, 3'b100, 2'b11}, // R2
    {4'd6, 1'b1, 2'd2, 16'h0009, 3'b000, 2'b11}, // R6 write force
    {4'd6, 1'b0, 2'd0, 16'h0000, 3'b000, 2'b01}, // R6 force applied
    {4'd6, 1'b0, 2'd0, 16'h0000, 3'b111, 2'b01}, // R6 events ignored
    {4'd7, 1'b1, 2'd2, 16'h000E, 3'b000, 2'b01}, // R7 A high, B value 3
    {4'd7, 1'b0, 2'd0, 16'h0000, 3'b000, 2'b11}, // R7 value 3 = no force
    {4'd7, 1'b1, 2'd2, 16'h0000, 3'b000, 2'b11}, // R7 release
    {4'd7, 1'b0, 2'd0, 16'h0000, 3'b001, 2'b10}, // R7 level kept
    {4'd9, 1'b1, 2'd0, 16'h0021, 3'b000, 2'b10}, // R9 A inverted
    {4'd9, 1'b1, 2'd1, 16'h0201, 3'b000, 2'b10}, // R9 B inverted
    {4'd9, 1'b0, 2'd0, 16'h0000, 3'b100, 2'b00}, // R9 clear on zero
    {4'd9, 1'b0, 2'd0, 16'h0000, 3'b010, 2'b10}, // R9 set on cmpa
    {4'd9, 1'b0, 2'd0, 16'h0000, 3'b001, 2'b11}, // R9 set on cmpb
    {4'd10,1'b0, 2'd0, 16'h0000, 3'b000, 2'b11}  // R10 hold
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: a,b actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    evt_zero = 1'b0; evt_cmpa_up = 1'b0; evt_cmpb_up = 1'b0;
  endtask

  task automatic write_reg(input logic [1:0] addr, input logic [15:0] data);
    @(negedge clk);
    idle_inputs();
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(posedge clk);
    #1;
  endtask

  // Bench time base: returns high counts over 4 measured periods
  task automatic run_pwm(input int per, input int ca, input int cb,
                         output int hi_a, output int hi_b);
    hi_a = 0; hi_b = 0;
    for (int p = 0; p < 5; p++) begin
      for (int c = 0; c < per; c++) begin
        @(negedge clk);
        idle_inputs();
        evt_zero = (c == 0); evt_cmpa_up = (c == ca); evt_cmpb_up = (c == cb);
        @(posedge clk);
        #1;
        if (p > 0) begin
          hi_a += int'(pwm_a);
          hi_b += int'(pwm_b);
        end
      end
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_cnt(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int ha, hb;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", {pwm_a, pwm_b}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release", {pwm_a, pwm_b}, 2'b00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i][23]; wr_addr = VEC[i][22:21]; wr_data = VEC[i][20:5];
      evt_zero = VEC[i][4]; evt_cmpa_up = VEC[i][3]; evt_cmpb_up = VEC[i][2];
      @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d", VEC[i][27:24], i), {pwm_a, pwm_b}, VEC[i][1:0]);
    end

    // R8 normal polarity duty
    write_reg(2'd0, 16'h0012);
    write_reg(2'd1, 16'h0102);
    run_pwm(10, 3, 0, ha, hb);
    check_cnt("R8 A high ticks cmp=3", ha, 12);
    check_cnt("R8 B cmp=0 constant low", hb, 0);
    run_pwm(10, 9, 5, ha, hb);
    check_cnt("R8 A high ticks cmp=9", ha, 36);
    check_cnt("R8 B high ticks cmp=5", hb, 20);

    // R9 inverted polarity duty
    write_reg(2'd0, 16'h0021);
    write_reg(2'd1, 16'h0201);
    run_pwm(10, 3, 0, ha, hb);
    check_cnt("R9 A high ticks cmp=3", ha, 28);
    check_cnt("R9 B cmp=0 constant high", hb, 40);

    // R1 mid-run reset: asynchronous clear, then actions cleared
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {pwm_a, pwm_b}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    evt_zero = 1'b1; evt_cmpa_up = 1'b1; evt_cmpb_up = 1'b1;
    @(posedge clk);
    #1;
    check("R1 actions cleared", {pwm_a, pwm_b}, 2'b00);
    @(negedge clk);
    idle_inputs();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run incomplete, expected finish before 20000 cycles");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule